// File: doc/BRIEF.md
# DQS Sampling-Delay Calibration Sweeper

This block picks the sampling delay that a DDR pseudo-static RAM read path applies to its data strobe. A start pulse begins a sweep, typically issued once right after memory initialisation completes. The sweep steps a 5-bit delay-tap code upward from 0 to 31 and drives it on `tap_code`. At every tap the block makes two test reads through a request/acknowledge handshake to a transaction engine. The first read expects 0x55AA and the second expects 0xAA55. A tap counts as good only when both words come back intact.

When the sweep ends, the block reports the lowest and highest good taps and the width of the window between them. It also raises a flag if any bad tap lies inside that window. Success depends on the window reaching a minimum width, not on finding a single good tap. On success the block parks `tap_code` at the rounded-down midpoint of the window. On failure it parks `tap_code` at 0. A one-cycle done pulse marks the end of the sweep, and the results then stay stable until the next start.

Top module: `dqs_cal_sweep`

## Requirements
- R1: After reset, `rd_req`, `cal_done`, `cal_pass`, `phase_gap`, `tap_code`, `min_tap`, `max_tap`, `win_size` and `sel_tap` are all 0.
- R2: A `cal_start` pulse while idle sweeps `tap_code` through every value from 0 to 31 in ascending steps of one. `rd_req` stays low whenever no sweep is running.
- R3: Each tap gets two reads. A read holds `rd_req` high, with `rd_pat_sel` and `tap_code` stable, until the cycle in which `rd_ack` is high. The read with `rd_pat_sel`=0 expects 0x55AA and the read with `rd_pat_sel`=1 expects 0xAA55. A tap passes only when both words match.
- R4: `min_tap` and `max_tap` hold the lowest and highest passing taps. Both are 0 when no tap passes.
- R5: `win_size` equals `max_tap` - `min_tap` + 1, or 0 when no tap passes.
- R6: `cal_pass` is high exactly when `win_size` is 9 or more.
- R7: On pass, `sel_tap` and `tap_code` both equal floor((`min_tap`+`max_tap`)/2). On failure, both are 0.
- R8: `phase_gap` is 1 exactly when at least one failing tap lies strictly between `min_tap` and `max_tap`. A contiguous window gives 0.
- R9: `cal_done` is high for exactly one cycle per sweep. All results stay unchanged after it until the next `cal_start`.
- R10: A `cal_start` that arrives while a sweep is running is ignored. The sweep continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start pulse for one sweep |
| rd_req | output | 1 | Test-read request, held until acknowledged |
| rd_pat_sel | output | 1 | Pattern being read: 0 for 0x55AA, 1 for 0xAA55 |
| rd_ack | input | 1 | Read data valid; completes the request |
| rd_data | input | 16 | Returned test word |
| tap_code | output | 5 | Delay-tap code driven to the delay line |
| min_tap | output | 5 | Lowest passing tap |
| max_tap | output | 5 | Highest passing tap |
| win_size | output | 6 | Passing-window width |
| sel_tap | output | 5 | Chosen centre tap |
| phase_gap | output | 1 | A failing tap lies inside the window |
| cal_done | output | 1 | One-cycle end-of-sweep pulse |
| cal_pass | output | 1 | Calibration succeeded |

## Verification
Two events can land in the same cycle. The first is the acknowledge of the last read at tap 31 together with the window update for that tap, where a tap-31 edge must still be recorded before the result is computed. The second is a fresh `cal_start` that meets a running sweep. The bench provokes the first with windows that end at tap 31 and with windows that fill the whole range, and judges it by the reported maximum tap and width. It provokes the second by pulsing start in the middle of a sweep, and judges it by seeing that `tap_code` does not fall back to 0 and that the results are still correct. The responder's acknowledge latency is randomised between 0 and 2 wait cycles, so reads of both patterns complete at varied offsets.

// File: rtl/dqscal_pkg.sv
package dqscal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SWEEP  = 2'd1,
    CAL_SETTLE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/dqscal_probe.sv
// Runs the two-pattern read pair for one tap and reports a verdict.
module dqscal_probe #(
  parameter int                 DATA_W = 16,
  parameter logic [DATA_W-1:0]  PAT_A  = 16'h55AA,
  parameter logic [DATA_W-1:0]  PAT_B  = 16'hAA55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic              rd_pat_sel,
  output logic              done,
  output logic              ok
);
  logic busy_q, busy_d;
  logic sel_q, sel_d;
  logic bad_q, bad_d;
  logic done_q, done_d;
  logic ok_q, ok_d;

  always_comb begin
    busy_d = busy_q;
    sel_d  = sel_q;
    bad_d  = bad_q;
    done_d = 1'b0;
    ok_d   = ok_q;
    if (!busy_q && go) begin
      busy_d = 1'b1;
      sel_d  = 1'b0;
      bad_d  = 1'b0;
    end else if (busy_q && rd_ack) begin
      if (!sel_q) begin
        sel_d = 1'b1;
        bad_d = (rd_data != PAT_A);
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
        ok_d   = !bad_q && (rd_data == PAT_B);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
      bad_q  <= bad_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign rd_req     = busy_q;
  assign rd_pat_sel = sel_q;
  assign done       = done_q;
  assign ok         = ok_q;
endmodule

// File: rtl/dqscal_window.sv
// Tracks first and last passing tap of an ascending sweep, plus holes.
module dqscal_window #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             ok,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] lo,
  output logic [TAP_W-1:0] hi,
  output logic             hole
);
  logic             found_d;
  logic [TAP_W-1:0] lo_d, hi_d;
  logic             hole_d;
  logic [TAP_W:0]   next_adj;

  assign next_adj = {1'b0, hi} + 1'b1;

  always_comb begin
    found_d = found;
    lo_d    = lo;
    hi_d    = hi;
    hole_d  = hole;
    if (clr) begin
      found_d = 1'b0;
      lo_d    = '0;
      hi_d    = '0;
      hole_d  = 1'b0;
    end else if (upd && ok) begin
      found_d = 1'b1;
      hi_d    = tap;
      if (!found) lo_d = tap;
      else if ({1'b0, tap} != next_adj) hole_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0;
      lo    <= '0;
      hi    <= '0;
      hole  <= 1'b0;
    end else begin
      found <= found_d;
      lo    <= lo_d;
      hi    <= hi_d;
      hole  <= hole_d;
    end
  end
endmodule

// File: rtl/dqs_cal_sweep.sv
module dqs_cal_sweep #(
  parameter int TAP_W   = 5,
  parameter int DATA_W  = 16,
  parameter int MIN_WIN = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  output logic              rd_req,
  output logic              rd_pat_sel,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic [TAP_W-1:0]  tap_code,
  output logic [TAP_W-1:0]  min_tap,
  output logic [TAP_W-1:0]  max_tap,
  output logic [TAP_W:0]    win_size,
  output logic [TAP_W-1:0]  sel_tap,
  output logic              phase_gap,
  output logic              cal_done,
  output logic              cal_pass
);
  import dqscal_pkg::*;

  localparam logic [TAP_W-1:0] TAP_LAST = {TAP_W{1'b1}};
  localparam logic [TAP_W:0]   WIN_MIN  = (TAP_W+1)'(MIN_WIN);

  cal_state_e       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             go_q, go_d;
  logic             clr_c, load_c;
  logic             pr_done, pr_ok;
  logic             w_found, w_hole;
  logic [TAP_W-1:0] w_lo, w_hi;
  logic [TAP_W:0]   win_c;
  logic [TAP_W:0]   sum_c;
  logic [TAP_W-1:0] mid_c;
  logic             pass_c;
  logic             sweeping;

  dqscal_probe #(.DATA_W(DATA_W)) u_probe (
    .clk(clk), .rst_n(rst_n), .go(go_q), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .rd_pat_sel(rd_pat_sel), .done(pr_done), .ok(pr_ok)
  );

  dqscal_window #(.TAP_W(TAP_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr_c), .upd(pr_done), .ok(pr_ok),
    .tap(tap_q), .found(w_found), .lo(w_lo), .hi(w_hi), .hole(w_hole)
  );

  assign win_c  = w_found ? ({1'b0, w_hi} - {1'b0, w_lo} + 1'b1) : '0;
  assign sum_c  = {1'b0, w_lo} + {1'b0, w_hi};
  assign mid_c  = sum_c[TAP_W:1];
  assign pass_c = (win_c >= WIN_MIN);
  assign sweeping = (state_q != CAL_IDLE);

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    go_d    = 1'b0;
    clr_c   = 1'b0;
    load_c  = 1'b0;
    unique case (state_q)
      CAL_IDLE: if (cal_start) begin
        state_d = CAL_SWEEP;
        tap_d   = '0;
        go_d    = 1'b1;
        clr_c   = 1'b1;
      end
      CAL_SWEEP: if (pr_done) begin
        if (tap_q == TAP_LAST) state_d = CAL_SETTLE;
        else begin
          tap_d = tap_q + 1'b1;
          go_d  = 1'b1;
        end
      end
      CAL_SETTLE: begin
        state_d = CAL_IDLE;
        load_c  = 1'b1;
        tap_d   = pass_c ? mid_c : '0;
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      tap_q   <= '0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      go_q    <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_tap   <= '0;
      max_tap   <= '0;
      win_size  <= '0;
      sel_tap   <= '0;
      phase_gap <= 1'b0;
      cal_pass  <= 1'b0;
      cal_done  <= 1'b0;
    end else begin
      cal_done <= load_c;
      if (clr_c) begin
        min_tap   <= '0;
        max_tap   <= '0;
        win_size  <= '0;
        sel_tap   <= '0;
        phase_gap <= 1'b0;
        cal_pass  <= 1'b0;
      end else if (load_c) begin
        min_tap   <= w_lo;
        max_tap   <= w_hi;
        win_size  <= win_c;
        sel_tap   <= pass_c ? mid_c : '0;
        phase_gap <= w_hole;
        cal_pass  <= pass_c;
      end
    end
  end

  assign tap_code = tap_q;
endmodule

// File: rtl/dqscal_checker.sv
module dqscal_checker #(
  parameter int TAP_W   = 5,
  parameter int MIN_WIN = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_start,
  input logic             rd_req,
  input logic             rd_ack,
  input logic             rd_pat_sel,
  input logic [TAP_W-1:0] tap_code,
  input logic [TAP_W-1:0] min_tap,
  input logic [TAP_W-1:0] max_tap,
  input logic [TAP_W:0]   win_size,
  input logic             cal_done,
  input logic             cal_pass,
  input logic             sweeping
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_pat_sel) && $stable(tap_code))); // R3
  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && $past(sweeping) && !cal_done && (tap_code != $past(tap_code)))
      |-> (tap_code == $past(tap_code) + 1'b1)); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sweeping |-> !rd_req); // R2
  AST_PASS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pass |-> (win_size >= (TAP_W+1)'(MIN_WIN))); // R6
  AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pass |-> (max_tap >= min_tap)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweeping && !cal_start) |=> ($stable(win_size) && $stable(cal_pass) && $stable(tap_code))); // R9
endmodule

bind dqs_cal_sweep dqscal_checker #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_pat_sel(rd_pat_sel), .tap_code(tap_code), .min_tap(min_tap), .max_tap(max_tap),
  .win_size(win_size), .cal_done(cal_done), .cal_pass(cal_pass), .sweeping(sweeping)
);

// File: tb/sim_dqs_cal_sweep.sv
module sim_dqs_cal_sweep;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cal_start;
  logic        rd_req, rd_pat_sel, rd_ack;
  logic [15:0] rd_data;
  logic [4:0]  tap_code, min_tap, max_tap, sel_tap;
  logic [5:0]  win_size;
  logic        phase_gap, cal_done, cal_pass;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  int done_cnt = 0;
  logic [31:0] map_a, map_b;
  int lat = 0;

  dqs_cal_sweep u0 (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .rd_req(rd_req),
    .rd_pat_sel(rd_pat_sel), .rd_ack(rd_ack), .rd_data(rd_data),
    .tap_code(tap_code), .min_tap(min_tap), .max_tap(max_tap),
    .win_size(win_size), .sel_tap(sel_tap), .phase_gap(phase_gap),
    .cal_done(cal_done), .cal_pass(cal_pass)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (cal_done) done_cnt++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Pattern responder: random 0..2 wait cycles, one-cycle acknowledge.
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0; rd_data = 16'h0; lat = 0;
    end else if (rd_ack) begin
      rd_ack = 1'b0;
      lat = int'($urandom % 3);
    end else if (rd_req) begin
      if (lat == 0) begin
        rd_ack = 1'b1;
        if (!rd_pat_sel) rd_data = map_a[tap_code] ? 16'h55AA : 16'h54AA;
        else             rd_data = map_b[tap_code] ? 16'hAA55 : 16'hAB55;
      end else lat--;
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] span(input int lo, input int hi);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  task automatic pulse_start();
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
  endtask

  task automatic run_cal(input logic [31:0] a, input logic [31:0] b, input bit mid_start);
    logic [31:0] good;
    int e_lo, e_hi, e_win, e_sel, e_gap, e_pass, d0, t_before, guard;
    good = a & b;
    e_lo = 0; e_hi = 0; e_win = 0; e_gap = 0;
    for (int i = 31; i >= 0; i--) if (good[i]) e_lo = i;
    for (int i = 0; i < 32; i++) if (good[i]) e_hi = i;
    if (good != 0) begin
      e_win = e_hi - e_lo + 1;
      for (int i = 0; i < 32; i++) if (i > e_lo && i < e_hi && !good[i]) e_gap = 1;
    end
    e_pass = (e_win >= 9) ? 1 : 0;
    e_sel  = e_pass ? (e_lo + e_hi) / 2 : 0;
    map_a = a; map_b = b;
    d0 = done_cnt;
    pulse_start();
    if (mid_start) begin
      repeat (60) @(negedge clk);
      t_before = int'(tap_code);
      pulse_start();
      @(negedge clk);
      chk(int'(tap_code) >= t_before, "R10", "tap after mid-sweep start", tap_code, t_before);
    end
    guard = 0;
    while (done_cnt == d0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
    chk(min_tap == e_lo, "R4", "min_tap", min_tap, e_lo);
    chk(max_tap == e_hi, "R4", "max_tap", max_tap, e_hi);
    chk(win_size == e_win, "R5", "win_size", win_size, e_win);
    chk(cal_pass == e_pass, "R6", "cal_pass", cal_pass, e_pass);
    chk(sel_tap == e_sel, "R7", "sel_tap", sel_tap, e_sel);
    chk(tap_code == e_sel, "R7", "tap_code", tap_code, e_sel);
    chk(phase_gap == e_gap, "R8", "phase_gap", phase_gap, e_gap);
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1 && win_size == e_win && tap_code == e_sel && cal_pass == e_pass,
        "R9", "results held", win_size, e_win);
  endtask

  initial begin
    cal_start = 1'b0; map_a = '0; map_b = '0;
    rst_n = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rd_req == 0 && cal_done == 0 && cal_pass == 0 && phase_gap == 0, "R1",
        "control outputs in reset", {rd_req, cal_done, cal_pass, phase_gap}, 0);
    chk(tap_code == 0 && min_tap == 0 && max_tap == 0 && win_size == 0 && sel_tap == 0,
        "R1", "result outputs in reset", win_size, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_req == 0, "R2", "no request while idle", rd_req, 0);

    // R2/R3: nominal window 2..17 -> width 16, centre 9
    run_cal(span(2, 17), span(2, 17), 1'b0);
    // R6: width exactly 9 passes, width 8 fails
    run_cal(span(20, 28), span(20, 28), 1'b0);
    run_cal(span(20, 27), span(20, 27), 1'b0);
    // R4/R5: nothing passes
    run_cal(32'h0, 32'hFFFF_FFFF, 1'b0);
    // full range, window ending at tap 31
    run_cal(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_cal(span(23, 31), span(23, 31), 1'b0);
    // R3: second pattern alone fails inside window -> hole (R8)
    run_cal(span(4, 20), span(4, 20) & ~32'h0000_0400, 1'b0);
    // R3: first pattern alone fails at edge
    run_cal(span(3, 15) & ~32'h0000_0008, span(3, 15), 1'b0);
    // R10: start during a sweep is ignored
    run_cal(span(5, 25), span(5, 25), 1'b1);

    for (int k = 0; k < 8; k++) begin
      int lo, hi;
      logic [31:0] m, mb;
      lo = int'($urandom % 32);
      hi = lo + int'($urandom % (32 - lo));
      m  = span(lo, hi);
      mb = m;
      if ($urandom % 2) mb[$urandom % 32] = 1'b0;
      run_cal(m, mb, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule